// File: doc/BRIEF.md
# Snooping Three-State Cache Coherence Controller

This block holds the coherence state, tag and data of every line of one small direct-mapped private cache that shares a snooping bus with identical caches. It serves load and store requests from its processor, turns misses into bus transactions, and watches the transactions of the other caches so that its own copies stay legal. It enforces a single-writer, multiple-reader rule. A line is either owned and dirty in exactly one cache, or readable in any number of caches, or absent.

Each line is Invalid (I, `2'b00`), Shared (S, `2'b01`) or Modified (M, `2'b10`). A two-state control machine sequences the local side. In IDLE it completes hits in the same cycle. On a miss it moves to ACQUIRE, raises a bus request and holds it until granted. When the grant comes, a dirty victim is first written back. The miss command then completes the request and the machine returns to IDLE. Snoops are handled in a single cycle by a separate decision path. They take priority over the local side. When a snooped line is Modified, its data is supplied on the bus in that same cycle. A probe port reports the state that a given address has in this cache.

Bus transactions take one cycle. In the grant cycle the winner drives a command. All other caches see it as a snoop in that cycle. The bus read data is the flushed line if a snooper supplies one, and memory otherwise.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line reads Invalid on the probe, and the probe never shows the unused code `2'b11`.
- R2: A load whose line is absent or holds another tag is a read miss. It issues bus command RD (`3'd1`) once granted, returns the bus read data, and leaves the line Shared.
- R3: A store whose line is absent or holds another tag is a write miss. It issues RDX (`3'd2`) and leaves the line Modified, holding the stored value.
- R4: A store that hits a Shared line issues UPG (`3'd3`) and leaves the line Modified. Every other cache's copy becomes Invalid.
- R5: A load hit in S or M, or a store hit in M, completes with no bus command and keeps the state.
- R6: A snooped RDX or UPG to a line held here in S or M makes that line Invalid.
- R7: A snooped RD to a line held here in M moves it to S and supplies the line data through snp_flush and snp_data in the snoop cycle. A snooped RD to an S line leaves it S. Flush happens only for RD or RDX snoops.
- R8: Across all caches an address has at most one M copy, and never an M copy together with S copies. Every load returns the most recently stored value.
- R9: A miss whose victim is Modified under another tag first issues WB (`3'd4`) with the victim's address and data. The request stays raised for the miss command that follows.
- R10: In a cycle with snp_valid high, cpu_ready is low. A raised bus_req stays raised until bus_gnt.
- R11: cpu_ready is high only while cpu_valid is high. A bus command other than NONE (`3'd0`) is driven only while both bus_req and bus_gnt are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes at the next edge |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 3 | Command driven while granted: 0 NONE, 1 RD, 2 RDX, 3 UPG, 4 WB |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data for RD or RDX |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Snooped command |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Supplied dirty data |
| probe_addr | input | ADDR_W | Address to inspect |
| probe_state | output | 2 | State of probe_addr in this cache |

## Verification
A wrong line state is visible at the ports in one of three ways. A stale load value shows on cpu_rdata when the load completes. A missing or extra command appears on bus_cmd in the grant cycle of the next access. A flush can be missing from the snoop cycle of another cache's read. Each of these shows within a few cycles of the faulty transition. Three controllers on one bus with a shared memory are swept on every cycle through the probe for the single-writer invariant. Each load is compared with a shadow copy of the last store. Directed sequences pin down the exact command list and the resulting states for upgrade, flush and dirty eviction.

// File: rtl/msi_pkg.sv
`timescale 1ns/10ps
package msi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_M = 2'b10
    } line_st_e;

    typedef enum logic [2:0] {
        BC_NONE = 3'd0,
        BC_RD   = 3'd1,
        BC_RDX  = 3'd2,
        BC_UPG  = 3'd3,
        BC_WB   = 3'd4
    } bus_cmd_e;

    typedef enum logic {
        FS_IDLE,
        FS_ACQUIRE
    } ctrl_st_e;
endpackage

// File: rtl/msi_line_store.sv
`timescale 1ns/10ps
module msi_line_store #(
    parameter int LINES  = 4,
    parameter int IDX_W  = $clog2(LINES),
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [1:0]        upd_state,
    input  logic              upd_tag_en,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic              upd_data_en,
    input  logic [DATA_W-1:0] upd_data,
    output logic [1:0]        st_q   [LINES],
    output logic [TAG_W-1:0]  tag_q  [LINES],
    output logic [DATA_W-1:0] data_q [LINES]
);
    import msi_pkg::*;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel;
        assign sel = upd_en && (upd_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= ST_I;
            end else if (sel) begin
                st_q[g] <= upd_state;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && upd_tag_en)  tag_q[g]  <= upd_tag;
            if (sel && upd_data_en) data_q[g] <= upd_data;
        end
    end
endmodule

// File: rtl/msi_snoop_logic.sv
`timescale 1ns/10ps
module msi_snoop_logic #(
    parameter int TAG_W = 4
) (
    input  logic             snp_valid,
    input  logic [2:0]       snp_cmd,
    input  logic [1:0]       line_st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             upd,
    output logic [1:0]       nxt_st,
    output logic             flush
);
    import msi_pkg::*;

    logic held;
    assign held = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);

    always_comb begin
        upd    = 1'b0;
        nxt_st = line_st;
        flush  = 1'b0;
        if (held) begin
            unique case (bus_cmd_e'(snp_cmd))
                BC_RD: begin
                    if (line_st == ST_M) begin
                        upd    = 1'b1;
                        nxt_st = ST_S;
                        flush  = 1'b1;
                    end
                end
                BC_RDX: begin
                    upd    = 1'b1;
                    nxt_st = ST_I;
                    flush  = (line_st == ST_M);
                end
                BC_UPG: begin
                    upd    = 1'b1;
                    nxt_st = ST_I;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_snoop_ctrl.sv
`timescale 1ns/10ps
module msi_snoop_ctrl #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic [1:0]        probe_state
);
    import msi_pkg::*;

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [1:0]        st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    logic [IDX_W-1:0] c_idx, s_idx, p_idx;
    logic [TAG_W-1:0] c_tag, s_tag, p_tag;
    assign c_idx = cpu_addr[IDX_W-1:0];
    assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];
    assign p_idx = probe_addr[IDX_W-1:0];
    assign p_tag = probe_addr[ADDR_W-1:IDX_W];

    logic c_match, c_hit, c_own, c_shared, c_dirty_victim;
    assign c_match        = (tag_q[c_idx] == c_tag);
    assign c_hit          = c_match && (st_q[c_idx] != ST_I);
    assign c_own          = c_match && (st_q[c_idx] == ST_M);
    assign c_shared       = c_match && (st_q[c_idx] == ST_S);
    assign c_dirty_victim = !c_match && (st_q[c_idx] == ST_M);

    logic       s_upd, s_flush;
    logic [1:0] s_st;

    msi_snoop_logic #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .line_st   (st_q[s_idx]),
        .line_tag  (tag_q[s_idx]),
        .snp_tag   (s_tag),
        .upd       (s_upd),
        .nxt_st    (s_st),
        .flush     (s_flush)
    );

    assign snp_flush   = s_flush;
    assign snp_data    = s_flush ? data_q[s_idx] : '0;
    assign probe_state = (tag_q[p_idx] == p_tag) ? st_q[p_idx] : ST_I;

    ctrl_st_e          state_q, state_d;
    logic              l_en, l_tag_en, l_data_en;
    logic [1:0]        l_state;
    logic [DATA_W-1:0] l_data;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_rdata = data_q[c_idx];
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = '0;
        bus_wdata = '0;
        l_en      = 1'b0;
        l_state   = ST_I;
        l_tag_en  = 1'b0;
        l_data_en = 1'b0;
        l_data    = cpu_wdata;
        unique case (state_q)
            FS_IDLE: begin
                if (cpu_valid && !snp_valid) begin
                    if (cpu_we ? c_own : c_hit) begin
                        cpu_ready = 1'b1;
                        if (cpu_we) begin
                            l_en      = 1'b1;
                            l_state   = ST_M;
                            l_data_en = 1'b1;
                        end
                    end else begin
                        state_d = FS_ACQUIRE;
                    end
                end
            end
            FS_ACQUIRE: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    if (c_dirty_victim) begin
                        bus_cmd   = BC_WB;
                        bus_addr  = {tag_q[c_idx], c_idx};
                        bus_wdata = data_q[c_idx];
                        l_en      = 1'b1;
                        l_state   = ST_I;
                    end else begin
                        bus_addr  = cpu_addr;
                        cpu_ready = 1'b1;
                        state_d   = FS_IDLE;
                        l_en      = 1'b1;
                        l_tag_en  = 1'b1;
                        l_data_en = 1'b1;
                        if (cpu_we) begin
                            bus_cmd = c_shared ? BC_UPG : BC_RDX;
                            l_state = ST_M;
                        end else begin
                            bus_cmd   = BC_RD;
                            l_state   = ST_S;
                            l_data    = bus_rdata;
                            cpu_rdata = bus_rdata;
                        end
                    end
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    msi_line_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (s_upd || l_en),
        .upd_idx    (s_upd ? s_idx : c_idx),
        .upd_state  (s_upd ? s_st : l_state),
        .upd_tag_en (!s_upd && l_tag_en),
        .upd_tag    (c_tag),
        .upd_data_en(!s_upd && l_data_en),
        .upd_data   (l_data),
        .st_q       (st_q),
        .tag_q      (tag_q),
        .data_q     (data_q)
    );
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
`timescale 1ns/10ps
module msi_snoop_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_valid,
    input logic       cpu_ready,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic [2:0] bus_cmd,
    input logic       snp_valid,
    input logic [2:0] snp_cmd,
    input logic       snp_flush,
    input logic [1:0] probe_state
);
    AST_STATE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) probe_state != 2'b11); // R1
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) cpu_ready |-> cpu_valid); // R11
    AST_CMD_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n) (bus_cmd != 3'd0) |-> (bus_gnt && bus_req)); // R11
    AST_SNOOP_BEATS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n) snp_valid |-> !cpu_ready); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (bus_req && !bus_gnt) |=> bus_req); // R10
    AST_FLUSH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) snp_flush |-> (snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd2))); // R7
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n) (bus_cmd == 3'd4) |=> bus_req); // R9
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk u_chk (.*);

// File: tb/tb_msi_snoop_ctrl.sv
`timescale 1ns/10ps
module tb_msi_snoop_ctrl;
    localparam int NC = 3;
    localparam int AW = 6;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    logic          cv [NC];
    logic          cwe [NC];
    logic [AW-1:0] caddr [NC];
    logic [DW-1:0] cwd [NC];
    logic          crdy [NC];
    logic [DW-1:0] crd [NC];
    logic          breq [NC];
    logic          bgnt [NC];
    logic [2:0]    bcmd [NC];
    logic [AW-1:0] badr [NC];
    logic [DW-1:0] bwd [NC];
    logic          sval [NC];
    logic          fl [NC];
    logic [DW-1:0] fdat [NC];
    logic [1:0]    pst [NC];
    logic [AW-1:0] paddr;

    logic [2:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata, fl_data;
    logic          any_fl;
    logic [DW-1:0] mem  [64];
    logic [DW-1:0] gold [64];
    int rr;

    int nchecks = 0;
    int nfail   = 0;

    for (genvar i = 0; i < NC; i++) begin : g_cache
        msi_snoop_ctrl dut (
            .clk(clk), .rst_n(rst_n),
            .cpu_valid(cv[i]), .cpu_we(cwe[i]), .cpu_addr(caddr[i]), .cpu_wdata(cwd[i]),
            .cpu_ready(crdy[i]), .cpu_rdata(crd[i]),
            .bus_req(breq[i]), .bus_gnt(bgnt[i]), .bus_cmd(bcmd[i]), .bus_addr(badr[i]),
            .bus_wdata(bwd[i]), .bus_rdata(bus_rdata),
            .snp_valid(sval[i]), .snp_cmd(bus_cmd), .snp_addr(bus_addr),
            .snp_flush(fl[i]), .snp_data(fdat[i]),
            .probe_addr(paddr), .probe_state(pst[i])
        );
    end

    always_comb begin
        bit found;
        found = 1'b0;
        for (int i = 0; i < NC; i++) bgnt[i] = 1'b0;
        for (int k = 0; k < NC; k++) begin
            if (!found && breq[(rr + k) % NC]) begin
                bgnt[(rr + k) % NC] = 1'b1;
                found = 1'b1;
            end
        end
    end

    always_comb begin
        bus_cmd = '0; bus_addr = '0; bus_wdata = '0; fl_data = '0; any_fl = 1'b0;
        for (int i = 0; i < NC; i++) begin
            bus_cmd   = bus_cmd | bcmd[i];
            bus_addr  = bus_addr | badr[i];
            bus_wdata = bus_wdata | bwd[i];
            if (fl[i]) begin
                any_fl  = 1'b1;
                fl_data = fl_data | fdat[i];
            end
        end
        for (int i = 0; i < NC; i++) sval[i] = (bus_cmd != 3'd0) && !bgnt[i];
        bus_rdata = any_fl ? fl_data : mem[bus_addr];
    end

    always @(posedge clk) begin
        if (!rst_n) rr <= 0;
        else begin
            for (int i = 0; i < NC; i++) if (bgnt[i]) rr <= (i + 1) % NC;
            if (bus_cmd == 3'd4) mem[bus_addr] <= bus_wdata;
            if (any_fl) mem[bus_addr] <= fl_data;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic probe(input int c, input logic [AW-1:0] a, output logic [1:0] st);
        paddr = a;
        #0.1;
        st = pst[c];
    endtask

    task automatic op(input int c, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd, output int n, output logic [2:0] k0, output logic [2:0] k1);
        n = 0; k0 = 0; k1 = 0; rd = '0;
        @(negedge clk);
        cv[c] = 1'b1; cwe[c] = we; caddr[c] = a; cwd[c] = d;
        forever begin
            #1;
            if (bgnt[c] && bus_cmd != 3'd0) begin
                if (n == 0) k0 = bus_cmd; else k1 = bus_cmd;
                n++;
            end
            if (crdy[c]) begin
                rd = crd[c];
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        cv[c] = 1'b0;
    endtask

    task automatic sweep_invariant();
        for (int a = 0; a < 8; a++) begin
            int nm, ns;
            nm = 0; ns = 0;
            paddr = AW'(a);
            #0.1;
            for (int c = 0; c < NC; c++) begin
                if (pst[c] == 2'b10) nm++;
                if (pst[c] == 2'b01) ns++;
            end
            chk("R8", "single writer", 32'((nm > 1) || (nm == 1 && ns > 0)), 32'd0);
        end
    endtask

    initial begin
        #(200000 * 10);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic [1:0]    st;
        logic [2:0]    k0, k1;
        int            n;
        bit            done [NC];

        for (int i = 0; i < NC; i++) begin
            cv[i] = 0; cwe[i] = 0; caddr[i] = '0; cwd[i] = '0; done[i] = 0;
        end
        for (int a = 0; a < 64; a++) begin
            mem[a]  = DW'(a * 3);
            gold[a] = DW'(a * 3);
        end
        paddr = '0;
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int c = 0; c < NC; c++)
            for (int a = 0; a < 8; a++) begin
                probe(c, AW'(a), st);
                chk("R1", "reset state", 32'(st), 32'd0);
            end
        chk("R11", "ready idle", 32'(crdy[0]), 32'd0);

        // R2: read miss
        op(0, 0, 6'd1, 8'h00, rd, n, k0, k1);
        chk("R2", "rd data", 32'(rd), 32'd3);
        chk("R2", "rd cmd", 32'(k0), 32'd1);
        probe(0, 6'd1, st);
        chk("R2", "rd state S", 32'(st), 32'd1);

        // R5: read hit in S, no bus
        op(0, 0, 6'd1, 8'h00, rd, n, k0, k1);
        chk("R5", "hit no cmd", 32'(n), 32'd0);
        chk("R5", "hit data", 32'(rd), 32'd3);

        op(1, 0, 6'd1, 8'h00, rd, n, k0, k1);
        chk("R7", "S kept on snooped RD", 32'(rd), 32'd3);
        probe(0, 6'd1, st);
        chk("R7", "cache0 still S", 32'(st), 32'd1);

        // R4 / R6: upgrade
        op(0, 1, 6'd1, 8'hA5, rd, n, k0, k1);
        chk("R4", "upg cmd", 32'(k0), 32'd3);
        probe(0, 6'd1, st);
        chk("R4", "owner M", 32'(st), 32'd2);
        probe(1, 6'd1, st);
        chk("R6", "other invalid", 32'(st), 32'd0);

        // R5: write hit in M
        op(0, 1, 6'd1, 8'h5A, rd, n, k0, k1);
        chk("R5", "M write no cmd", 32'(n), 32'd0);
        probe(0, 6'd1, st);
        chk("R5", "still M", 32'(st), 32'd2);

        // R7: flush on snooped RD to M
        op(2, 0, 6'd1, 8'h00, rd, n, k0, k1);
        chk("R7", "flushed data", 32'(rd), 32'h5A);
        probe(0, 6'd1, st);
        chk("R7", "M to S", 32'(st), 32'd1);
        probe(2, 6'd1, st);
        chk("R2", "reader S", 32'(st), 32'd1);

        // R3: write miss over clean victim
        op(2, 1, 6'd5, 8'h33, rd, n, k0, k1);
        chk("R3", "rdx cmd", 32'(k0), 32'd2);
        chk("R3", "one cmd", 32'(n), 32'd1);
        probe(2, 6'd5, st);
        chk("R3", "filled M", 32'(st), 32'd2);

        // R9: dirty eviction
        op(2, 1, 6'd1, 8'h44, rd, n, k0, k1);
        chk("R9", "first WB", 32'(k0), 32'd4);
        chk("R9", "then RDX", 32'(k1), 32'd2);
        probe(0, 6'd1, st);
        chk("R6", "snooped RDX invalidates", 32'(st), 32'd0);
        op(1, 0, 6'd5, 8'h00, rd, n, k0, k1);
        chk("R9", "written back value", 32'(rd), 32'h33);
        op(1, 0, 6'd1, 8'h00, rd, n, k0, k1);
        chk("R8", "latest store", 32'(rd), 32'h44);
        gold[1] = 8'h44;
        gold[5] = 8'h33;

        // random mixed traffic
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            for (int i = 0; i < NC; i++) begin
                if (!cv[i] || done[i]) begin
                    done[i] = 0;
                    if ($urandom % 2) begin
                        cv[i]    = 1'b1;
                        cwe[i]   = 1'($urandom % 2);
                        caddr[i] = AW'($urandom % 8);
                        cwd[i]   = DW'($urandom);
                    end else begin
                        cv[i] = 1'b0;
                    end
                end
            end
            #1;
            for (int i = 0; i < NC; i++) begin
                if (sval[i] && crdy[i]) chk("R10", "ready during snoop", 32'd1, 32'd0);
                if (crdy[i] && !cv[i]) chk("R11", "ready without valid", 32'd1, 32'd0);
                if (cv[i] && crdy[i]) begin
                    if (!cwe[i]) chk("R8", "load value", 32'(crd[i]), 32'(gold[caddr[i]]));
                    done[i] = 1;
                end
            end
            for (int i = 0; i < NC; i++)
                if (cv[i] && crdy[i] && cwe[i]) gold[caddr[i]] = cwd[i];
            sweep_invariant();
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule